// File: doc/BRIEF.md
# Serial ADC Sample Capture Controller

This block sits on the host side of a 12-bit micro-power serial converter and paces its conversions. When enabled, it starts a frame by pulling the active-low chip select low. It then produces a serial clock from the system clock, with a half period set at run time. On each falling edge it captures one bit from the converter's data line. A frame is sixteen bits long: four bits that must read as zero, then the twelve result bits with the most significant bit first.

After the last bit the controller raises chip select. One system clock later it presents the twelve-bit result with a single-cycle valid strobe and a flag that reports a nonzero leading bit. A run-time frame period, counted in system clocks, sets the throughput. A fixed minimum idle time between frames still applies when the period is shorter than a frame. During that idle time the converter powers itself down.

Top module: `adc_frame_ctrl`

## Requirements
- R1: During and right after reset, `adc_cs_n` and `adc_sclk` are high, and `busy`, `result_valid`, `frame_error` and `result` are zero.
- R2: A frame begins (`adc_cs_n` falls) only on a clock where `enable` is high, no frame is active and the period counter has expired. `busy` is high exactly while `adc_cs_n` is low.
- R3: `adc_sclk` is high whenever `adc_cs_n` is high. In a frame, its first falling edge comes H system clocks after `adc_cs_n` falls, and it then toggles every H system clocks. H is `div_half`, and a value of 0 is used as 1.
- R4: Each frame has exactly 16 falling edges of `adc_sclk`. `adc_cs_n` rises together with the rising edge that follows the 16th falling edge, so a frame lasts 32·H clocks.
- R5: `adc_sdata` is sampled at each falling edge. The bits of samples 5 to 16 form `result`, with sample 5 as bit 11 and sample 16 as bit 0.
- R6: `result` and `result_valid` update one system clock after `adc_cs_n` rises. `result_valid` is high for exactly one clock per frame.
- R7: `frame_error` is 1 with a result when any of samples 1 to 4 of that frame read as 1, and 0 otherwise.
- R8: With `enable` held high and `period` at least 32·H+3, successive falling edges of `adc_cs_n` are exactly `period` clocks apart.
- R9: Between frames `adc_cs_n` stays high for at least 3 clocks, whatever `period` is (0 included).
- R10: `div_half` and `period` are taken at frame start. Changing them during a frame does not affect that frame's clock timing or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| div_half | input | 8 | Serial clock half period in system clocks |
| period | input | 16 | Frame-start spacing in system clocks |
| adc_sdata | input | 1 | Serial data from converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame in progress |
| result | output | 12 | Last captured sample |
| result_valid | output | 1 | One-clock strobe for a new result |
| frame_error | output | 1 | A leading bit of the last frame was 1 |

## Verification
Chip select falls on the first clock edge at which the start condition holds. The serial clock's first fall comes H edges later, and chip select rises 32·H edges after the start. The result, valid strobe and error flag follow one edge after that. The bench keeps a behavioural model that advances on the same edges from the same inputs, and it compares every output at the falling clock edge between updates. A separate converter model drives the data line and changes it only after each falling edge of the serial clock. The bench also times the gap between frames and counts the falling edges in each frame.

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int DATA_W    = 12,
  parameter int LEAD_W    = 4,
  parameter int DIV_W     = 8,
  parameter int PER_W     = 16,
  parameter int QUIET_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div_half,
  input  logic [PER_W-1:0]  period,
  input  logic              adc_sdata,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              frame_error
);
  localparam int FRAME_BITS = LEAD_W + DATA_W;
  localparam int ECW = $clog2(FRAME_BITS + 1);
  localparam int QW  = $clog2(QUIET_CYC + 1);

  logic [DIV_W-1:0]      h_q, div_cnt;
  logic [PER_W-1:0]      per_cnt;
  logic [QW-1:0]         quiet_cnt;
  logic [ECW-1:0]        fall_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  fin;

  wire [DIV_W-1:0] h_eff = (div_half == '0) ? DIV_W'(1) : div_half;
  wire tick  = busy && (div_cnt == DIV_W'(1));
  wire fall  = tick && adc_sclk;
  wire last  = tick && !adc_sclk && (fall_cnt == ECW'(FRAME_BITS));
  wire start = !busy && enable && (per_cnt == '0) && (quiet_cnt == '0);

  assign busy = ~adc_cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_cs_n  <= 1'b1;
      adc_sclk  <= 1'b1;
      h_q       <= DIV_W'(1);
      div_cnt   <= DIV_W'(1);
      per_cnt   <= '0;
      quiet_cnt <= '0;
      fall_cnt  <= '0;
      shreg     <= '0;
      fin       <= 1'b0;
    end else begin
      fin <= last;
      if (start) begin
        adc_cs_n <= 1'b0;
        adc_sclk <= 1'b1;
        h_q      <= h_eff;
        div_cnt  <= h_eff;
        fall_cnt <= '0;
      end else if (tick) begin
        div_cnt  <= h_q;
        adc_sclk <= last ? 1'b1 : ~adc_sclk;
        if (last) adc_cs_n <= 1'b1;
      end else if (busy) begin
        div_cnt <= div_cnt - DIV_W'(1);
      end
      if (fall) begin
        fall_cnt <= fall_cnt + ECW'(1);
        shreg    <= {shreg[FRAME_BITS-2:0], adc_sdata};
      end
      if (last)                 quiet_cnt <= QW'(QUIET_CYC);
      else if (quiet_cnt != '0) quiet_cnt <= quiet_cnt - QW'(1);
      if (start)                per_cnt <= (period == '0) ? '0 : period - PER_W'(1);
      else if (per_cnt != '0)   per_cnt <= per_cnt - PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
      frame_error  <= 1'b0;
    end else begin
      result_valid <= fin;
      if (fin) begin
        result      <= shreg[DATA_W-1:0];
        frame_error <= |shreg[FRAME_BITS-1:DATA_W];
      end
    end
  end
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic busy,
  input logic result_valid
);
  logic [7:0] falls;
  logic       sclk_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      falls  <= '0;
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= adc_sclk;
      cs_d   <= adc_cs_n;
      if (cs_d && !adc_cs_n)                       falls <= '0;
      else if (!adc_cs_n && sclk_d && !adc_sclk)   falls <= falls + 8'd1;
    end
  end

  assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(enable));
  assert_idle_clock_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);
  assert_clock_moves_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_sclk) |-> $past(busy));
  assert_sixteen_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> (falls == 8'(FRAME_BITS)));
  assert_valid_follows_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |=> result_valid);
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  assert_valid_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> $past(adc_cs_n) && !$past(adc_cs_n, 2));
  assert_quiet_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(adc_cs_n, 2) && $past(adc_cs_n, 3));
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(.FRAME_BITS(LEAD_W + DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk), .busy(busy), .result_valid(result_valid)
);

// File: tb/adc_frame_ctrl_tb.sv
`timescale 1ns/1ps
module adc_frame_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  div_half = 8'd2;
  logic [15:0] period = 16'd0;
  logic        adc_sdata;
  logic        adc_cs_n, adc_sclk, busy, result_valid, frame_error;
  logic [11:0] result;

  int checks = 0, fails = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  adc_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_half(div_half),
    .period(period), .adc_sdata(adc_sdata), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .busy(busy), .result(result),
    .result_valid(result_valid), .frame_error(frame_error)
  );

  function automatic logic [15:0] word_of(int i);
    logic [11:0] d;
    logic [3:0]  l;
    d = 12'((i * 1637 + 12'h5A3) ^ (i << 7));
    if (i == 1) d = 12'hFFF;
    if (i == 2) d = 12'h000;
    if (i == 4) d = 12'h800;
    l = (i % 4 == 3) ? 4'((i % 7) + 1) : 4'h0;
    return {l, d};
  endfunction

  // converter model: next bit appears after each falling serial clock
  int c_idx = 0, c_bit = 15;
  logic [15:0] c_word = '0;
  always @(negedge adc_cs_n) begin c_word = word_of(c_idx); c_idx++; c_bit = 15; end
  always @(negedge adc_sclk) if (!adc_cs_n && c_bit > 0) c_bit--;
  assign adc_sdata = adc_cs_n ? 1'b0 : c_word[c_bit];

  // behavioural reference, advanced on the same clock edges
  int m_t, m_h, m_per, m_quiet, m_fidx;
  bit m_cs, m_fin, m_valid, m_err, m_busy_old, m_start, m_end;
  logic [11:0] m_res;
  logic [15:0] m_word;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = 1; m_t = 0; m_h = 1; m_per = 0; m_quiet = 0; m_fidx = 0;
      m_fin = 0; m_valid = 0; m_err = 0; m_res = '0; m_word = '0;
    end else begin
      m_busy_old = !m_cs;
      m_valid = m_fin;
      if (m_fin) begin m_res = m_word[11:0]; m_err = |m_word[15:12]; end
      m_start = !m_busy_old && enable && m_per == 0 && m_quiet == 0;
      m_end = 0;
      if (m_busy_old) begin
        m_t++;
        if (m_t == 32 * m_h) begin m_cs = 1; m_end = 1; end
      end
      if (m_end) m_quiet = 2;
      else if (m_quiet > 0) m_quiet--;
      if (m_start) begin
        m_per = (period == 0) ? 0 : int'(period) - 1;
        m_cs = 0; m_t = 0;
        m_h = (div_half == 0) ? 1 : int'(div_half);
        m_word = word_of(m_fidx); m_fidx++;
      end else if (m_per > 0) m_per--;
      m_fin = m_end;
    end
  end

  task automatic cmp(string req, string sig, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h at %0t", req, phase, sig, act, exp, $time);
    end
  endtask

  bit run_cmp = 0;
  always @(negedge clk) if (run_cmp) begin
    cmp("R2", "adc_cs_n", 32'(adc_cs_n), 32'(m_cs));
    cmp("R2", "busy", 32'(busy), 32'(!m_cs));
    cmp("R3", "adc_sclk", 32'(adc_sclk), m_cs ? 32'd1 : 32'(((m_t / m_h) % 2) == 0));
    cmp("R6", "result_valid", 32'(result_valid), 32'(m_valid));
    cmp("R5", "result", 32'(result), 32'(m_res));
    cmp("R7", "frame_error", 32'(frame_error), 32'(m_err));
  end

  // frame edge counting and gap timing
  int nfall = 0;
  realtime t_fall = 0, t_rise = 0;
  bit have_rise = 0, chk_spacing = 0, have_fall = 0;
  always @(negedge adc_sclk) if (!adc_cs_n) nfall++;
  always @(posedge adc_cs_n) if (rst_n) begin
    cmp("R4", "falls_per_frame", 32'(nfall), 32'd16);
    t_rise = $realtime; have_rise = 1;
  end
  always @(negedge adc_cs_n) if (rst_n) begin
    nfall = 0;
    if (have_rise) cmp("R9", "quiet_ge_3", 32'(($realtime - t_rise) >= 24.0), 32'd1);
    if (chk_spacing && have_fall)
      cmp("R8", "start_spacing", 32'(int'(($realtime - t_fall) / 8.0)), 32'(period));
    t_fall = $realtime; have_fall = 1;
  end

  task automatic wait_frames(int n);
    repeat (n) @(posedge result_valid);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    phase = "R1";
    cmp("R1", "reset_cs_n", 32'(adc_cs_n), 32'd1);
    cmp("R1", "reset_sclk", 32'(adc_sclk), 32'd1);
    cmp("R1", "reset_busy", 32'(busy), 32'd0);
    cmp("R1", "reset_valid", 32'(result_valid), 32'd0);
    cmp("R1", "reset_result", 32'(result), 32'd0);
    rst_n = 1'b1;
    run_cmp = 1;
    repeat (40) @(negedge clk);
    cmp("R2", "no_start_without_enable", 32'(adc_cs_n), 32'd1);

    phase = "R8"; div_half = 8'd2; period = 16'd100;
    enable = 1'b1; chk_spacing = 1;
    wait_frames(4);
    chk_spacing = 0;

    phase = "R9"; div_half = 8'd1; period = 16'd0;
    wait_frames(4);

    phase = "R3"; div_half = 8'd0; period = 16'd5;
    wait_frames(2);

    phase = "R7"; div_half = 8'd3; period = 16'd120;
    wait_frames(4);

    phase = "R10"; div_half = 8'd2; period = 16'd90;
    @(negedge adc_cs_n); repeat (10) @(negedge clk);
    div_half = 8'd5; period = 16'd7;
    wait_frames(1);
    div_half = 8'd1; period = 16'd40;
    @(negedge adc_cs_n); repeat (6) @(negedge clk);
    div_half = 8'd4;
    wait_frames(2);

    phase = "R2"; div_half = 8'd2; period = 16'd0;
    @(negedge adc_cs_n); repeat (3) @(negedge clk);
    enable = 1'b0;
    repeat (150) @(negedge clk);
    cmp("R2", "idle_after_disable", 32'(adc_cs_n), 32'd1);

    run_cmp = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired in phase %s actual=hung expected=done", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule